// File: doc/BRIEF.md
# Paired Byte Register File

This block holds six general-purpose byte registers, B, C, D, E, H and L, and groups them into three 16-bit pairs: BC, DE and HL. In each pair the first register is the high-order byte and the second is the low-order byte. A sequencer drives one operation code per clock cycle, along with a register select or a pair select. The block carries out single-byte writes and register-to-register copies. It also carries out whole-pair work: loading a 16-bit immediate, incrementing or decrementing a pair, swapping HL with DE, and adding a pair into HL.

HL is always visible as the memory pointer. Two transfer operations raise a one-cycle strobe that hands the current HL value to an external stack pointer or program counter. The 16-bit add reports only a carry. It does this through a registered carry output and a valid strobe that appear in the cycle after the add. Increment and decrement produce no flag at all.

The byte read port is combinational. A read always returns the value the register held before the current clock edge, even when the same register is being written in that cycle.

Top module: `regpair_file`

## Requirements
- R1: A synchronous active-high reset clears all six registers, the carry output and the carry valid strobe to zero.
- R2: With operation code 1, `wr_data_i` is written into the register chosen by `wr_sel_i`. The register codes are B=0, C=1, D=2, E=3, H=4, L=5. `rd_data_i` combinationally shows the register chosen by `rd_sel_i`. A read of the register being written in the same cycle returns the old value, and the new value is visible from the next cycle.
- R3: With operation code 2, the register at `rd_sel_i` is copied into the register at `wr_sel_i`, and the source register keeps its value.
- R4: With operation code 3, `imm_i` is loaded into the pair at `pair_sel_i`. The pair codes are BC=0, DE=1, HL=2. `imm_i[15:8]` goes to the high byte (B, D or H) and `imm_i[7:0]` goes to the low byte.
- R5: Operation codes 4 and 5 increment and decrement the selected pair modulo 2^16, so FFFFh+1 gives 0000h and 0000h-1 gives FFFFh. Neither operation raises the carry output or the carry valid strobe.
- R6: Operation code 6 swaps H with D and L with E in a single cycle.
- R7: Operation code 7 writes HL plus the selected pair into HL. In the following cycle `cy_vld_o` is 1 and `cy_o` carries the carry out of bit 15. In every other cycle both outputs are 0. Selecting HL as the operand doubles HL.
- R8: `hl_ptr_o` always shows {H, L}.
- R9: Operation code 8 raises `xfer_sp_o` and operation code 9 raises `xfer_pc_o`, each only in its own cycle, with `xfer_data_o` equal to {H, L}. Neither operation changes any register.
- R10: Register codes 6 and 7, pair code 3 and operation codes 0 and 10 to 15 change no register. A read of register code 6 or 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code for this cycle |
| wr_sel_i | input | 3 | Destination register code |
| rd_sel_i | input | 3 | Read or copy-source register code |
| pair_sel_i | input | 2 | Pair code for pair operations |
| wr_data_i | input | 8 | Byte for a single-register write |
| imm_i | input | 16 | Immediate value for a pair load |
| rd_data_o | output | 8 | Selected register value (old value on a same-cycle write) |
| hl_ptr_o | output | 16 | Memory pointer {H, L} |
| cy_o | output | 1 | Carry out of the last pair add |
| cy_vld_o | output | 1 | Carry output is valid this cycle |
| xfer_sp_o | output | 1 | Hand HL to the stack pointer |
| xfer_pc_o | output | 1 | Hand HL to the program counter |
| xfer_data_o | output | 16 | HL value offered for the transfer |

## Verification
The bench builds the block with its default byte width of 8, which makes a pair 16 bits wide. At that width, the wrap points FFFFh and 0000h and the carry out of bit 15 can each be reached with a single immediate load followed by one operation. Directed vectors hit these edges, the same-cycle read-during-write case, the swap, and every out-of-range code. A long pseudo-random sequence then mixes all sixteen operation codes against a behavioural model of the six registers.

// File: rtl/regpair_pkg.sv
package regpair_pkg;

    localparam int NPAIR  = 3;
    localparam int NREG   = 2 * NPAIR;
    localparam int RSEL_W = 3;
    localparam int PSEL_W = 2;
    localparam int OP_W   = 4;

    localparam logic [PSEL_W-1:0] PAIR_BC = 2'd0;
    localparam logic [PSEL_W-1:0] PAIR_DE = 2'd1;
    localparam logic [PSEL_W-1:0] PAIR_HL = 2'd2;

    localparam int IDX_D = 2;
    localparam int IDX_E = 3;
    localparam int IDX_H = 4;
    localparam int IDX_L = 5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 4'd0,
        OP_WRITE  = 4'd1,
        OP_COPY   = 4'd2,
        OP_LDPAIR = 4'd3,
        OP_INC    = 4'd4,
        OP_DEC    = 4'd5,
        OP_XCHG   = 4'd6,
        OP_ADDHL  = 4'd7,
        OP_TOSP   = 4'd8,
        OP_TOPC   = 4'd9
    } rp_op_e;

    function automatic logic reg_ok(input logic [RSEL_W-1:0] s);
        return int'(s) < NREG;
    endfunction

    function automatic logic pair_ok(input logic [PSEL_W-1:0] p);
        return int'(p) < NPAIR;
    endfunction

    function automatic int hi_of(input logic [PSEL_W-1:0] p);
        return 2 * int'(p);
    endfunction

    function automatic int lo_of(input logic [PSEL_W-1:0] p);
        return 2 * int'(p) + 1;
    endfunction

endpackage

// File: rtl/regpair_arith.sv
module regpair_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] inc_o,
    output logic [W-1:0] dec_o,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    logic [W:0] wide;

    assign wide    = {1'b0, a_i} + {1'b0, b_i};
    assign sum_o   = wide[W-1:0];
    assign carry_o = wide[W];
    assign inc_o   = a_i + W'(1);
    assign dec_o   = a_i - W'(1);
endmodule

// File: rtl/regpair_bank.sv
module regpair_bank #(
    parameter int BYTE_W = 8,
    parameter int NREG   = 6
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic [NREG-1:0]              we_i,
    input  logic [NREG-1:0][BYTE_W-1:0]  nxt_i,
    output logic [NREG-1:0][BYTE_W-1:0]  q_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk_i) begin
            if (rst_i)
                q_o[g] <= '0;
            else if (we_i[g])
                q_o[g] <= nxt_i[g];
        end
    end

    // R10 / R9: a cycle with no write enable leaves every register as it was
    a_r10_hold_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/regpair_file.sv
module regpair_file
    import regpair_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [OP_W-1:0]     op_i,
    input  logic [RSEL_W-1:0]   wr_sel_i,
    input  logic [RSEL_W-1:0]   rd_sel_i,
    input  logic [PSEL_W-1:0]   pair_sel_i,
    input  logic [BYTE_W-1:0]   wr_data_i,
    input  logic [2*BYTE_W-1:0] imm_i,
    output logic [BYTE_W-1:0]   rd_data_o,
    output logic [2*BYTE_W-1:0] hl_ptr_o,
    output logic                cy_o,
    output logic                cy_vld_o,
    output logic                xfer_sp_o,
    output logic                xfer_pc_o,
    output logic [2*BYTE_W-1:0] xfer_data_o
);
    localparam int PAIR_W = 2 * BYTE_W;

    rp_op_e                         op;
    logic [NREG-1:0]                we;
    logic [NREG-1:0][BYTE_W-1:0]    nxt;
    logic [NREG-1:0][BYTE_W-1:0]    q;
    logic [NPAIR-1:0][PAIR_W-1:0]   pv;
    logic [PAIR_W-1:0]              sel_pair, hl, de;
    logic [PAIR_W-1:0]              inc_v, dec_v, sum_v;
    logic                           carry_v;
    logic                           cy_d, vld_d;

    assign op = rp_op_e'(op_i);

    regpair_bank #(.BYTE_W(BYTE_W), .NREG(NREG)) u_bank (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .we_i  (we),
        .nxt_i (nxt),
        .q_o   (q)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pv[p] = {q[2*p], q[2*p+1]};
    end

    assign hl       = pv[int'(PAIR_HL)];
    assign de       = pv[int'(PAIR_DE)];
    assign sel_pair = pair_ok(pair_sel_i) ? pv[pair_sel_i] : '0;

    regpair_arith #(.W(PAIR_W)) u_arith (
        .a_i     (sel_pair),
        .b_i     (hl),
        .inc_o   (inc_v),
        .dec_o   (dec_v),
        .sum_o   (sum_v),
        .carry_o (carry_v)
    );

    always_comb begin
        we    = '0;
        nxt   = q;
        cy_d  = 1'b0;
        vld_d = 1'b0;
        unique case (op)
            OP_WRITE: begin
                if (reg_ok(wr_sel_i)) begin
                    we[wr_sel_i]  = 1'b1;
                    nxt[wr_sel_i] = wr_data_i;
                end
            end
            OP_COPY: begin
                if (reg_ok(wr_sel_i) && reg_ok(rd_sel_i)) begin
                    we[wr_sel_i]  = 1'b1;
                    nxt[wr_sel_i] = q[rd_sel_i];
                end
            end
            OP_LDPAIR, OP_INC, OP_DEC: begin
                if (pair_ok(pair_sel_i)) begin
                    we[hi_of(pair_sel_i)] = 1'b1;
                    we[lo_of(pair_sel_i)] = 1'b1;
                    case (op)
                        OP_LDPAIR: {nxt[hi_of(pair_sel_i)], nxt[lo_of(pair_sel_i)]} = imm_i;
                        OP_INC:    {nxt[hi_of(pair_sel_i)], nxt[lo_of(pair_sel_i)]} = inc_v;
                        default:   {nxt[hi_of(pair_sel_i)], nxt[lo_of(pair_sel_i)]} = dec_v;
                    endcase
                end
            end
            OP_XCHG: begin
                we[IDX_D]  = 1'b1;
                we[IDX_E]  = 1'b1;
                we[IDX_H]  = 1'b1;
                we[IDX_L]  = 1'b1;
                nxt[IDX_H] = q[IDX_D];
                nxt[IDX_L] = q[IDX_E];
                nxt[IDX_D] = q[IDX_H];
                nxt[IDX_E] = q[IDX_L];
            end
            OP_ADDHL: begin
                if (pair_ok(pair_sel_i)) begin
                    we[IDX_H] = 1'b1;
                    we[IDX_L] = 1'b1;
                    {nxt[IDX_H], nxt[IDX_L]} = sum_v;
                    cy_d  = carry_v;
                    vld_d = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cy_o     <= 1'b0;
            cy_vld_o <= 1'b0;
        end else begin
            cy_o     <= cy_d;
            cy_vld_o <= vld_d;
        end
    end

    assign rd_data_o   = reg_ok(rd_sel_i) ? q[rd_sel_i] : '0;
    assign hl_ptr_o    = hl;
    assign xfer_sp_o   = (op == OP_TOSP);
    assign xfer_pc_o   = (op == OP_TOPC);
    assign xfer_data_o = hl;

    // R7: a valid pair add produces a carry strobe in the next cycle
    a_r7_carry_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        (op == OP_ADDHL && pair_ok(pair_sel_i)) |=> cy_vld_o);

    // R5: increment and decrement raise no flag output
    a_r5_no_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        (op == OP_INC || op == OP_DEC) |=> (!cy_vld_o && !cy_o));

    // R5: HL increment wraps modulo the pair width
    a_r5_hl_wrap_inc: assert property (@(posedge clk_i) disable iff (rst_i)
        (op == OP_INC && pair_sel_i == PAIR_HL) |=> hl_ptr_o == PAIR_W'($past(hl_ptr_o) + PAIR_W'(1)));

    // R6: after a swap HL holds the former DE
    a_r6_swap_hl: assert property (@(posedge clk_i) disable iff (rst_i)
        (op == OP_XCHG) |=> hl_ptr_o == $past(de));

    // R9: a transfer strobe leaves HL untouched
    a_r9_xfer_keeps_hl: assert property (@(posedge clk_i) disable iff (rst_i)
        (xfer_sp_o || xfer_pc_o) |=> $stable(hl_ptr_o));
endmodule

// File: tb/sim_regpair_file.sv
`timescale 1ns/1ps
module sim_regpair_file;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op;
    logic [2:0]  wr_sel, rd_sel;
    logic [1:0]  pair_sel;
    logic [7:0]  wr_data;
    logic [15:0] imm;
    logic [7:0]  rd_data;
    logic [15:0] hl_ptr, xfer_data;
    logic        cy, cy_vld, xfer_sp, xfer_pc;

    int    nvec  = 0;
    int    nfail = 0;
    bit    done  = 1'b0;
    int    m [6];
    int    ev, ec;
    string prev_tag = "R1";
    int    seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    regpair_file u0 (
        .clk_i(clk), .rst_i(rst), .op_i(op), .wr_sel_i(wr_sel), .rd_sel_i(rd_sel),
        .pair_sel_i(pair_sel), .wr_data_i(wr_data), .imm_i(imm), .rd_data_o(rd_data),
        .hl_ptr_o(hl_ptr), .cy_o(cy), .cy_vld_o(cy_vld), .xfer_sp_o(xfer_sp),
        .xfer_pc_o(xfer_pc), .xfer_data_o(xfer_data)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int pairv(input int p);
        return (m[2*p] << 8) | m[2*p+1];
    endfunction

    function automatic string op_tag(input int o);
        case (o)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4, 5: return "R5";
            6: return "R6";
            7: return "R7";
            8, 9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic step(input int o, input int ws, input int rs, input int ps,
                        input int wd, input int im, input string tag);
        int hl, s, pv;
        @(negedge clk);
        op = 4'(o); wr_sel = 3'(ws); rd_sel = 3'(rs); pair_sel = 2'(ps);
        wr_data = 8'(wd); imm = 16'(im);
        #1;
        hl = pairv(2);
        chk(tag, "rd_data", int'(rd_data), (rs < 6) ? m[rs] : 0);
        chk("R8", "hl_ptr", int'(hl_ptr), hl);
        chk("R9", "xfer_sp", int'(xfer_sp), (o == 8) ? 1 : 0);
        chk("R9", "xfer_pc", int'(xfer_pc), (o == 9) ? 1 : 0);
        if (o == 8 || o == 9) chk("R9", "xfer_data", int'(xfer_data), hl);
        chk(prev_tag, "cy_vld", int'(cy_vld), ev);
        chk(prev_tag, "cy", int'(cy), ec);
        ev = 0; ec = 0;
        case (o)
            1: if (ws < 6) m[ws] = wd & 8'hFF;
            2: if (ws < 6 && rs < 6) m[ws] = m[rs];
            3, 4, 5: if (ps < 3) begin
                pv = (o == 3) ? im : (o == 4) ? pairv(ps) + 1 : pairv(ps) - 1;
                pv = pv & 16'hFFFF;
                m[2*ps] = pv >> 8; m[2*ps+1] = pv & 8'hFF;
            end
            6: begin
                s = m[4]; m[4] = m[2]; m[2] = s;
                s = m[5]; m[5] = m[3]; m[3] = s;
            end
            7: if (ps < 3) begin
                s = hl + pairv(ps);
                m[4] = (s >> 8) & 8'hFF; m[5] = s & 8'hFF;
                ev = 1; ec = (s >> 16) & 1;
            end
            default: ;
        endcase
        prev_tag = tag;
    endtask

    task automatic sweep(input string tag);
        for (int r = 0; r < 8; r++) step(0, 0, r, 0, 0, 0, tag);
    endtask

    function automatic int rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        return seed & 32'h7FFF_FFFF;
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) m[i] = 0;
        ev = 0; ec = 0;
        rst = 1'b1; op = '0; wr_sel = '0; rd_sel = '0; pair_sel = '0; wr_data = '0; imm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        sweep("R1");

        // R2: writes with a same-cycle read of the written register
        for (int r = 0; r < 6; r++) step(1, r, r, 0, 8'h11 * (r + 1), 0, "R2");
        sweep("R2");

        // R3: copies, source preserved
        step(2, 5, 0, 0, 0, 0, "R3");
        step(2, 0, 3, 0, 0, 0, "R3");
        sweep("R3");

        // R4: pair loads
        step(3, 0, 0, 0, 0, 16'hA1B2, "R4");
        step(3, 0, 0, 1, 0, 16'hC3D4, "R4");
        step(3, 0, 0, 2, 0, 16'hE5F6, "R4");
        sweep("R4");

        // R5: wrap in both directions
        step(3, 0, 0, 2, 0, 16'hFFFF, "R5");
        step(4, 0, 0, 2, 0, 0, "R5");
        step(3, 0, 0, 0, 0, 16'h0000, "R5");
        step(5, 0, 0, 0, 0, 0, "R5");
        step(4, 0, 0, 1, 0, 0, "R5");
        sweep("R5");

        // R6: swap
        step(3, 0, 0, 2, 0, 16'h1234, "R6");
        step(6, 0, 4, 0, 0, 0, "R6");
        sweep("R6");

        // R7: add with and without carry, HL doubled
        step(3, 0, 0, 2, 0, 16'hF000, "R7");
        step(3, 0, 0, 0, 0, 16'h2001, "R7");
        step(7, 0, 0, 0, 0, 0, "R7");
        step(7, 0, 0, 1, 0, 0, "R7");
        step(3, 0, 0, 2, 0, 16'h8000, "R7");
        step(7, 0, 0, 2, 0, 0, "R7");
        step(0, 0, 4, 0, 0, 0, "R7");

        // R9: transfers
        step(3, 0, 0, 2, 0, 16'h5A3C, "R9");
        step(8, 0, 4, 0, 0, 0, "R9");
        step(9, 0, 5, 0, 0, 0, "R9");
        sweep("R9");

        // R10: out-of-range codes
        step(1, 6, 0, 0, 8'hEE, 0, "R10");
        step(1, 7, 0, 0, 8'hEE, 0, "R10");
        step(2, 1, 7, 0, 0, 0, "R10");
        step(3, 0, 0, 3, 0, 16'hBEEF, "R10");
        step(4, 0, 0, 3, 0, 0, "R10");
        step(7, 0, 0, 3, 0, 0, "R10");
        step(12, 0, 0, 0, 0, 0, "R10");
        sweep("R10");

        for (int k = 0; k < 2000; k++) begin
            int o;
            o = rnd() % 16;
            step(o, rnd() % 8, rnd() % 8, rnd() % 4, rnd() % 256, rnd() % 65536, op_tag(o));
        end
        sweep("R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule